// File: doc/BRIEF.md
# NAND Flash Bus Host Front End

This block sits between a processor register port and an 8-bit NAND flash device. Software places command, address and data bytes in a small ordered queue. A strobe engine drains the queue and turns each entry into one bus cycle. Command bytes are sent with the command latch line high. Address bytes are sent with the address latch line high. Data bytes are sent with both latch lines low. The queue reports when it is full, and software must not write to it while that flag is set.

A single-byte read has two phases. Software first writes any value to a read-request register. When the byte has been captured, a sticky ready flag is set, and the byte can then be read from a data register. Software clears the flag by writing a 1 to it. A page-control register starts a transfer of a whole page of 256 or 512 bytes. Page data moves over two valid/ready byte streams: one carries bytes read from the flash and one supplies bytes to program. A page-checksum accumulator folds in every byte of a page. Software clears it through a dedicated register before each page.

Both page streams follow the usual handshake: a byte moves on a clock edge where valid and ready are both high. On the read stream, the block holds valid high and keeps the data byte unchanged until ready is seen. It issues no further flash read until the byte it holds has been taken, so back-pressure stops the flash bus. On the write stream, the block raises ready only when it can start a bus cycle in the same edge, so a stalled source simply delays the page.

Top module: `nfc_host`

## Requirements
- R1: After reset the bus is idle: chip enable (active low), write strobe and read strobe are high; both latch lines, the data output enable, irq and the read-stream valid are low. STAT (address 1) reads 0x0004, and ISTAT (address 2) bits 2:1 read 0.
- R2: A write to address 4 (command) gives one write-strobe cycle with the command latch high. A write to address 5 (address) gives one with the address latch high. A write to address 6 (data) gives one with both latch lines low. The byte is `reg_wdata[7:0]`, and the cycles go out in the order written.
- R3: STAT bit 0 is 1 while the 4-entry queue holds 4 entries and 0 otherwise. STAT bit 2 is 1 when the queue is empty, and bit 3 is 1 while a bus cycle is in progress.
- R4: The write strobe stays low for wr_dly+1 clocks and the read strobe for rd_dly+1 clocks. CTRL (address 0) holds rd_dly in bits 5:2, wr_dly in bits 9:6 and the large-page select in bit 0. The two strobes are never low together.
- R5: A write of any value to address 7 gives exactly one read-strobe cycle. The byte on the data input is sampled on the rising edge of the read strobe. It then appears at address 8, and ISTAT bit 1 is set.
- R6: ISTAT bits 1 and 2 are cleared only by writing 1 to that bit position. Writing 0 leaves them set.
- R7: ISTAT bit 0 follows the ready/busy input (1 = ready) after a two-flop synchronizer.
- R8: Writing 1 to address 9 reads a whole page of 256 bytes (CTRL bit 0 = 0) or 512 bytes (CTRL bit 0 = 1). The bytes come out in order on the read stream, and the stream data is held while it is not accepted. ISTAT bit 2 is set at the end.
- R9: Writing 2 to address 9 takes one page of bytes from the write stream. Each byte goes out as a data bus cycle, and ISTAT bit 2 is set at the end.
- R10: Address 11 reads the XOR of all bytes moved in page transfers. Any write to address 10 clears it to 0.
- R11: `irq` is high when any ISTAT bit 2:0 is 1 while its bit in IMASK (address 3, 1 = masked) is 0. IMASK resets to 0x7.
- R12: A write to address 9 with a value other than 1 or 2 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt request |
| pg_rd_valid | output | 1 | Page read stream: byte valid |
| pg_rd_ready | input | 1 | Page read stream: sink ready |
| pg_rd_data | output | 8 | Page read stream: byte |
| pg_wr_valid | input | 1 | Page write stream: byte valid |
| pg_wr_ready | output | 1 | Page write stream: block ready |
| pg_wr_data | input | 8 | Page write stream: byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb | input | 1 | Ready/busy, 1 = ready |
| nand_dout | output | 8 | Data driven to the flash |
| nand_doe | output | 1 | Output enable for nand_dout |
| nand_din | input | 8 | Data returned by the flash |

## Verification
The checker assumes that software never writes to the command, address, data or read-request registers while the full flag is set. It also assumes that the strobe delay fields are changed only while the bus is quiet, because the strobe-width properties compare against the current field values. The bench keeps to both rules. It changes CTRL only after STAT reads back 0x0004. It fills the queue with exactly four waiting entries, one more byte being on the bus, and never pushes a fifth waiting entry. The read-stream sink drops ready in a repeating pattern so that the hold rule is exercised under the strobe timing.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_DATA = 2'd2,
    K_READ = 2'd3
  } op_kind_t;

  typedef struct packed {
    op_kind_t    kind;
    logic [7:0]  byte_v;
  } op_t;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_STAT   = 4'd1;
  localparam logic [3:0] A_ISTAT  = 4'd2;
  localparam logic [3:0] A_IMASK  = 4'd3;
  localparam logic [3:0] A_CMD    = 4'd4;
  localparam logic [3:0] A_ADDR   = 4'd5;
  localparam logic [3:0] A_DWR    = 4'd6;
  localparam logic [3:0] A_RDREQ  = 4'd7;
  localparam logic [3:0] A_RDATA  = 4'd8;
  localparam logic [3:0] A_PGCTL  = 4'd9;
  localparam logic [3:0] A_ECCRST = 4'd10;
  localparam logic [3:0] A_ECC    = 4'd11;

endpackage

// File: rtl/nfc_opq.sv
module nfc_opq
  import nfc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  op_t  push_op,
  input  logic pop,
  output op_t  head,
  output logic valid,
  output logic full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  op_t           slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign valid   = (cnt != '0);
  assign full    = (cnt == CMAX);
  assign head    = slots[rp];
  assign do_push = push && !full;
  assign do_pop  = pop && valid;

  always_ff @(posedge clk) begin
    if (do_push) slots[wp] <= push_op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/nfc_strobe.sv
module nfc_strobe
  import nfc_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] rd_dly,
  input  logic [DLY_W-1:0] wr_dly,
  input  logic             req_valid,
  input  op_t              req_op,
  output logic             req_ready,
  output logic             idle,
  output logic             done,
  output logic             done_read,
  output logic [7:0]       done_byte,
  output logic             we_n,
  output logic             re_n,
  output logic             cle,
  output logic             ale,
  output logic             doe,
  output logic [7:0]       dout,
  input  logic [7:0]       din
);
  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_HOLD} st_t;

  st_t              st;
  op_t              cur;
  logic [DLY_W-1:0] cnt;
  logic [7:0]       cap;
  logic             take, is_rd, active;

  assign req_ready = (st == ST_IDLE) || (st == ST_HOLD);
  assign take      = req_valid && req_ready;
  assign is_rd     = (cur.kind == K_READ);
  assign active    = (st != ST_IDLE);
  assign idle      = !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cur <= '{kind: K_CMD, byte_v: 8'h00};
      cnt <= '0;
      cap <= '0;
    end else if (take) begin
      st  <= ST_STROBE;
      cur <= req_op;
      cnt <= (req_op.kind == K_READ) ? rd_dly : wr_dly;
    end else begin
      case (st)
        ST_STROBE: begin
          if (cnt == '0) begin
            st <= ST_HOLD;
            if (is_rd) cap <= din;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign we_n      = !((st == ST_STROBE) && !is_rd);
  assign re_n      = !((st == ST_STROBE) && is_rd);
  assign cle       = active && (cur.kind == K_CMD);
  assign ale       = active && (cur.kind == K_ADDR);
  assign doe       = active && !is_rd;
  assign dout      = cur.byte_v;
  assign done      = (st == ST_HOLD);
  assign done_read = is_rd;
  assign done_byte = is_rd ? cap : cur.byte_v;
endmodule

// File: rtl/nfc_page.sv
module nfc_page
  import nfc_pkg::*;
#(
  parameter int PAGE_SMALL = 256,
  parameter int PAGE_LARGE = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_rd,
  input  logic       start_wr,
  input  logic       big_page,
  input  logic       str_ready,
  input  logic       str_idle,
  input  logic       str_done,
  input  logic [7:0] str_byte,
  output logic       active,
  output logic       finish,
  output logic       req_valid,
  output op_t        req_op,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data
);
  localparam int CNT_W = $clog2(PAGE_LARGE + 1);
  localparam logic [CNT_W-1:0] N_SMALL = CNT_W'(PAGE_SMALL);
  localparam logic [CNT_W-1:0] N_LARGE = CNT_W'(PAGE_LARGE);

  logic             is_wr, inflight, ov;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       odata;
  logic             left, take;

  assign left      = (cnt != '0);
  assign req_valid = active && left && (is_wr ? wr_valid : (!inflight && !ov));
  assign req_op    = is_wr ? '{kind: K_DATA, byte_v: wr_data}
                           : '{kind: K_READ, byte_v: 8'h00};
  assign take      = req_valid && str_ready;
  assign wr_ready  = active && is_wr && left && str_ready;
  assign finish    = active && !left && (is_wr ? str_idle : (!inflight && !ov));
  assign rd_valid  = ov;
  assign rd_data   = odata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      is_wr    <= 1'b0;
      cnt      <= '0;
      inflight <= 1'b0;
      ov       <= 1'b0;
      odata    <= '0;
    end else begin
      if (!active && (start_rd || start_wr)) begin
        active <= 1'b1;
        is_wr  <= start_wr;
        cnt    <= big_page ? N_LARGE : N_SMALL;
      end else if (finish) begin
        active <= 1'b0;
      end else if (take) begin
        cnt <= cnt - 1'b1;
      end
      if (take && !is_wr) inflight <= 1'b1;
      else if (active && !is_wr && str_done) inflight <= 1'b0;
      if (active && !is_wr && str_done && inflight) begin
        ov    <= 1'b1;
        odata <= str_byte;
      end else if (ov && rd_ready) begin
        ov <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nfc_host.sv
module nfc_host
  import nfc_pkg::*;
#(
  parameter int DLY_W      = 4,
  parameter int QDEPTH     = 4,
  parameter int PAGE_SMALL = 256,
  parameter int PAGE_LARGE = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wen,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        pg_rd_valid,
  input  logic        pg_rd_ready,
  output logic [7:0]  pg_rd_data,
  input  logic        pg_wr_valid,
  output logic        pg_wr_ready,
  input  logic [7:0]  pg_wr_data,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  input  logic        nand_rb,
  output logic [7:0]  nand_dout,
  output logic        nand_doe,
  input  logic [7:0]  nand_din
);
  localparam int RD_LSB = 2;
  localparam int WR_LSB = RD_LSB + DLY_W;

  logic [15:0]      ctrl_q;
  logic [2:0]       imask_q;
  logic             rd_rdy_q, pg_done_q;
  logic [7:0]       rdata_q, ecc_q;
  logic             rb_s1, rb_s2;
  logic             pend_q, pend_wr_q;
  logic [DLY_W-1:0] rd_dly, wr_dly;

  logic             q_push, q_pop, q_valid, q_full;
  op_t              q_in, q_head;
  logic             s_valid, s_ready, s_idle, s_done, s_done_rd;
  op_t              s_op;
  logic [7:0]       s_byte;
  logic             p_active, p_finish, p_req_valid, p_start;
  op_t              p_req_op;

  logic w_ctrl, w_istat, w_imask, w_pg, w_eccrst, w_queue;

  assign rd_dly = ctrl_q[RD_LSB +: DLY_W];
  assign wr_dly = ctrl_q[WR_LSB +: DLY_W];

  assign w_ctrl   = reg_wen && (reg_addr == A_CTRL);
  assign w_istat  = reg_wen && (reg_addr == A_ISTAT);
  assign w_imask  = reg_wen && (reg_addr == A_IMASK);
  assign w_pg     = reg_wen && (reg_addr == A_PGCTL);
  assign w_eccrst = reg_wen && (reg_addr == A_ECCRST);
  assign w_queue  = reg_wen && (reg_addr >= A_CMD) && (reg_addr <= A_RDREQ);

  always_comb begin
    q_in.byte_v = reg_wdata[7:0];
    case (reg_addr)
      A_CMD:   q_in.kind = K_CMD;
      A_ADDR:  q_in.kind = K_ADDR;
      A_DWR:   q_in.kind = K_DATA;
      default: q_in.kind = K_READ;
    endcase
  end

  assign q_push = w_queue && !q_full;
  assign q_pop  = q_valid && !p_active && s_ready;

  nfc_opq #(.DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_op(q_in), .pop(q_pop),
    .head(q_head), .valid(q_valid), .full(q_full)
  );

  assign s_valid = p_active ? p_req_valid : q_valid;
  assign s_op    = p_active ? p_req_op : q_head;

  nfc_strobe #(.DLY_W(DLY_W)) u_str (
    .clk(clk), .rst_n(rst_n), .rd_dly(rd_dly), .wr_dly(wr_dly),
    .req_valid(s_valid), .req_op(s_op), .req_ready(s_ready), .idle(s_idle),
    .done(s_done), .done_read(s_done_rd), .done_byte(s_byte),
    .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale),
    .doe(nand_doe), .dout(nand_dout), .din(nand_din)
  );

  assign p_start = pend_q && !q_valid && s_idle && !p_active;

  nfc_page #(.PAGE_SMALL(PAGE_SMALL), .PAGE_LARGE(PAGE_LARGE)) u_pg (
    .clk(clk), .rst_n(rst_n),
    .start_rd(p_start && !pend_wr_q), .start_wr(p_start && pend_wr_q),
    .big_page(ctrl_q[0]), .str_ready(s_ready), .str_idle(s_idle),
    .str_done(s_done), .str_byte(s_byte),
    .active(p_active), .finish(p_finish),
    .req_valid(p_req_valid), .req_op(p_req_op),
    .rd_valid(pg_rd_valid), .rd_ready(pg_rd_ready), .rd_data(pg_rd_data),
    .wr_valid(pg_wr_valid), .wr_ready(pg_wr_ready), .wr_data(pg_wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      imask_q   <= 3'b111;
      rd_rdy_q  <= 1'b0;
      pg_done_q <= 1'b0;
      rdata_q   <= '0;
      ecc_q     <= '0;
      rb_s1     <= 1'b0;
      rb_s2     <= 1'b0;
      pend_q    <= 1'b0;
      pend_wr_q <= 1'b0;
    end else begin
      rb_s1 <= nand_rb;
      rb_s2 <= rb_s1;
      if (w_ctrl)  ctrl_q  <= reg_wdata;
      if (w_imask) imask_q <= reg_wdata[2:0];

      if (s_done && s_done_rd && !p_active) begin
        rd_rdy_q <= 1'b1;
        rdata_q  <= s_byte;
      end else if (w_istat && reg_wdata[1]) begin
        rd_rdy_q <= 1'b0;
      end

      if (p_finish)                         pg_done_q <= 1'b1;
      else if (w_istat && reg_wdata[2])     pg_done_q <= 1'b0;

      if (w_pg && !pend_q && !p_active &&
          ((reg_wdata == 16'd1) || (reg_wdata == 16'd2))) begin
        pend_q    <= 1'b1;
        pend_wr_q <= (reg_wdata == 16'd2);
      end else if (p_start) begin
        pend_q <= 1'b0;
      end

      if (w_eccrst)                ecc_q <= '0;
      else if (s_done && p_active) ecc_q <= ecc_q ^ s_byte;
    end
  end

  assign nand_ce_n = !(!s_idle || q_valid || p_active || pend_q);
  assign irq       = |({pg_done_q, rd_rdy_q, rb_s2} & ~imask_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = {12'd0, !s_idle, !q_valid, (p_active || pend_q), q_full};
      A_ISTAT: reg_rdata = {13'd0, pg_done_q, rd_rdy_q, rb_s2};
      A_IMASK: reg_rdata = {13'd0, imask_q};
      A_RDATA: reg_rdata = {8'd0, rdata_q};
      A_ECC:   reg_rdata = {8'd0, ecc_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nfc_host_chk.sv
module nfc_host_chk #(
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             we_n,
  input logic             re_n,
  input logic             cle,
  input logic             ale,
  input logic             ce_n,
  input logic             doe,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [7:0]       rd_data,
  input logic             reg_wen,
  input logic [3:0]       reg_addr,
  input logic             q_full,
  input logic [DLY_W-1:0] wr_dly,
  input logic [DLY_W-1:0] rd_dly
);
  logic [DLY_W:0] we_lo, re_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo <= '0;
      re_lo <= '0;
    end else begin
      we_lo <= we_n ? '0 : we_lo + 1'b1;
      re_lo <= re_n ? '0 : re_lo + 1'b1;
    end
  end

  assert_strobes_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_lo == ({1'b0, wr_dly} + 1'b1)));

  assert_re_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(re_n) |-> (re_lo == ({1'b0, rd_dly} + 1'b1)));

  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  assert_ce_during_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !ce_n);

  assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !doe);

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && (reg_addr >= 4'd4) && (reg_addr <= 4'd7)) |-> !q_full);
endmodule

bind nfc_host nfc_host_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .we_n(nand_we_n), .re_n(nand_re_n),
  .cle(nand_cle), .ale(nand_ale), .ce_n(nand_ce_n), .doe(nand_doe),
  .rd_valid(pg_rd_valid), .rd_ready(pg_rd_ready), .rd_data(pg_rd_data),
  .reg_wen(reg_wen), .reg_addr(reg_addr), .q_full(q_full),
  .wr_dly(wr_dly), .rd_dly(rd_dly)
);

// File: tb/tb_nfc_host.sv
`timescale 1ns/1ps
module tb_nfc_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        irq;
  logic        pg_rd_valid, pg_wr_ready;
  logic        pg_rd_ready = 1'b0;
  logic [7:0]  pg_rd_data;
  logic        pg_wr_valid = 1'b0;
  logic [7:0]  pg_wr_data = 8'd0;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_doe;
  logic        nand_rb = 1'b1;
  logic [7:0]  nand_dout;
  logic [7:0]  nand_din = 8'd0;

  always #2.5 clk = ~clk;

  nfc_host dut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .pg_rd_valid(pg_rd_valid), .pg_rd_ready(pg_rd_ready), .pg_rd_data(pg_rd_data),
    .pg_wr_valid(pg_wr_valid), .pg_wr_ready(pg_wr_ready), .pg_wr_data(pg_wr_data),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_rb(nand_rb),
    .nand_dout(nand_dout), .nand_doe(nand_doe), .nand_din(nand_din)
  );

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;
  bit rdy_en = 1'b0;
  int cur_wr_dly = 0;
  int cur_rd_dly = 0;
  int we_lo = 0;
  int re_lo = 0;

  logic [9:0] exp_we[$];
  logic [7:0] nand_src[$];
  logic [7:0] exp_rd[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic src_push(input logic [7:0] b);
    nand_src.push_back(b);
    nand_din = nand_src[0];
  endtask

  always @(negedge clk) begin
    if (!nand_we_n) we_lo++;
    if (!nand_re_n) re_lo++;
  end

  // Scoreboard monitor: each completed write strobe against the queue (R2, R4)
  always @(posedge nand_we_n) begin
    if (rst_n) begin
      if (exp_we.size() == 0) begin
        vecs++; errs++;
        $display("FAIL R2 unexpected write cycle: actual 0x%0h expected none",
                 {nand_cle, nand_ale, nand_dout});
      end else begin
        logic [9:0] e;
        e = exp_we.pop_front();
        check("R2 write cycle latch/byte", {22'd0, nand_cle, nand_ale, nand_dout}, {22'd0, e});
        check("R4 write strobe width", we_lo, cur_wr_dly + 1);
      end
      we_lo = 0;
    end
  end

  // Flash model: supplies the next byte, pops it when read strobe rises (R5, R4)
  always @(posedge nand_re_n) begin
    if (rst_n) begin
      check("R4 read strobe width", re_lo, cur_rd_dly + 1);
      re_lo = 0;
      if (nand_src.size() == 0) begin
        vecs++; errs++;
        $display("FAIL R12 unexpected read cycle: actual 1 expected 0");
      end else begin
        void'(nand_src.pop_front());
        nand_din = (nand_src.size() != 0) ? nand_src[0] : 8'h00;
      end
    end
  end

  // Stream monitor: page read bytes against expected queue (R8)
  always @(negedge clk) begin
    if (rst_n && pg_rd_valid && pg_rd_ready) begin
      if (exp_rd.size() == 0) begin
        vecs++; errs++;
        $display("FAIL R8 extra stream byte: actual 0x%0h expected none", pg_rd_data);
      end else begin
        check("R8 page read byte", {24'd0, pg_rd_data}, {24'd0, exp_rd.pop_front()});
      end
    end
  end

  initial begin
    int tick = 0;
    forever begin
      @(posedge clk);
      #1;
      tick++;
      pg_rd_ready = rdy_en && ((tick % 3) != 2);
    end
  end

  task automatic reg_wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wen = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_istat(input int b, input int limit);
    logic [15:0] v;
    int n = 0;
    do begin
      reg_rd(4'd2, v);
      n++;
    end while (!v[b] && n < limit);
  endtask

  task automatic wait_quiet();
    logic [15:0] v;
    int n = 0;
    do begin
      reg_rd(4'd1, v);
      n++;
    end while (v != 16'h0004 && n < 2000);
  endtask

  function automatic logic [7:0] rd_pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] wr_pat(input int i);
    return 8'((i * 13 + 5) & 255);
  endfunction

  task automatic drive_page(input int n);
    int i = 0;
    bit hs;
    @(posedge clk); #1;
    pg_wr_valid = 1'b1;
    pg_wr_data = wr_pat(0);
    while (i < n) begin
      @(negedge clk);
      hs = pg_wr_ready;
      @(posedge clk); #1;
      if (hs) begin
        i++;
        pg_wr_data = wr_pat(i);
        if (i == n) pg_wr_valid = 1'b0;
      end
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vecs++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  x;

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 pins idle", {26'd0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_doe},
          {26'd0, 6'b111000});
    check("R1 irq/stream", {30'd0, irq, pg_rd_valid}, 32'd0);
    reg_rd(4'd1, v);
    check("R1 STAT", {16'd0, v}, 32'h4);
    repeat (3) @(posedge clk);
    reg_rd(4'd2, v);
    check("R1 ISTAT, R7 ready", {16'd0, v}, 32'h1);

    // R2, R4: command/address/data cycles, wr_dly=1, rd_dly=2
    reg_wr(4'd0, 16'h0048);
    cur_wr_dly = 1; cur_rd_dly = 2;
    exp_we.push_back({2'b10, 8'h90}); reg_wr(4'd4, 16'h0090);
    exp_we.push_back({2'b01, 8'h00}); reg_wr(4'd5, 16'h0000);
    exp_we.push_back({2'b00, 8'h5A}); reg_wr(4'd6, 16'hAB5A);
    wait_quiet();
    check("R2 all cycles seen", exp_we.size(), 0);

    // R5: two-phase single read
    src_push(8'hA5);
    reg_wr(4'd7, 16'h1234);
    wait_istat(1, 200);
    reg_rd(4'd8, v);
    check("R5 read data", {16'd0, v}, 32'hA5);
    check("R5 one read strobe", nand_src.size(), 0);
    // R11: masked by default
    check("R11 irq masked", {31'd0, irq}, 0);
    reg_wr(4'd3, 16'h0005);
    @(negedge clk);
    check("R11 irq unmasked", {31'd0, irq}, 1);
    // R6: write-one-to-clear
    reg_wr(4'd2, 16'h0000);
    reg_rd(4'd2, v);
    check("R6 zero write keeps", {31'd0, v[1]}, 1);
    reg_wr(4'd2, 16'h0002);
    reg_rd(4'd2, v);
    check("R6 one write clears", {31'd0, v[1]}, 0);
    check("R11 irq drops", {31'd0, irq}, 0);
    reg_wr(4'd3, 16'h0007);

    // R3: full flag, slow write strobe
    reg_wr(4'd0, 16'h03C8);
    cur_wr_dly = 15;
    for (int i = 0; i < 5; i++) begin
      exp_we.push_back({2'b00, 8'(8'h30 + i)});
      reg_wr(4'd6, 16'(8'h30 + i));
    end
    reg_rd(4'd1, v);
    check("R3 full set", {31'd0, v[0]}, 1);
    check("R3 bus busy", {31'd0, v[3]}, 1);
    wait_quiet();
    reg_rd(4'd1, v);
    check("R3 drained", {16'd0, v}, 32'h4);
    check("R3 all cycles seen", exp_we.size(), 0);

    // R7: ready/busy tracking
    nand_rb = 1'b0;
    repeat (4) @(posedge clk);
    reg_rd(4'd2, v);
    check("R7 busy seen", {31'd0, v[0]}, 0);
    nand_rb = 1'b1;
    repeat (4) @(posedge clk);
    reg_rd(4'd2, v);
    check("R7 ready seen", {31'd0, v[0]}, 1);

    // R8, R10: small page read with back-pressure
    reg_wr(4'd0, 16'h0000);
    cur_wr_dly = 0; cur_rd_dly = 0;
    reg_wr(4'd10, 16'h0000);
    x = 8'h00;
    for (int i = 0; i < 256; i++) begin
      src_push(rd_pat(i));
      exp_rd.push_back(rd_pat(i));
      x = x ^ rd_pat(i);
    end
    rdy_en = 1'b1;
    reg_wr(4'd9, 16'h0001);
    wait_istat(2, 5000);
    rdy_en = 1'b0;
    check("R8 all page bytes", exp_rd.size(), 0);
    check("R8 flash reads used", nand_src.size(), 0);
    reg_rd(4'd11, v);
    check("R10 page checksum", {16'd0, v}, {24'd0, x});
    reg_wr(4'd2, 16'h0004);
    reg_rd(4'd2, v);
    check("R6 page done cleared", {31'd0, v[2]}, 0);
    reg_wr(4'd10, 16'h0000);
    reg_rd(4'd11, v);
    check("R10 checksum reset", {16'd0, v}, 0);

    // R12: unsupported page command
    reg_wr(4'd9, 16'h0003);
    repeat (20) @(posedge clk);
    reg_rd(4'd1, v);
    check("R12 nothing started", {16'd0, v}, 32'h4);
    reg_rd(4'd2, v);
    check("R12 no page done", {31'd0, v[2]}, 0);

    // R9, R10: large page write
    reg_wr(4'd0, 16'h0001);
    x = 8'h00;
    for (int i = 0; i < 512; i++) begin
      exp_we.push_back({2'b00, wr_pat(i)});
      x = x ^ wr_pat(i);
    end
    reg_wr(4'd9, 16'h0002);
    drive_page(512);
    wait_istat(2, 5000);
    check("R9 all page bytes written", exp_we.size(), 0);
    reg_rd(4'd11, v);
    check("R10 write checksum", {16'd0, v}, {24'd0, x});
    reg_rd(4'd1, v);
    check("R9 idle after page", {16'd0, v}, 32'h4);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule